// File: doc/BRIEF.md
# Event Queue Writer with Completion Interrupt

This block posts small event records into a circular queue that lives in host memory. A client hands it a 16-bit event kind and a 16-bit origin. The block accepts the request when the queue has room. It computes the slot address from the programmed base address and ring size, and presents a 32-byte record to a DMA engine as a single write request tagged with the issue pointer. When the DMA engine reports that a write has landed, the block advances the committed head pointer. One cycle later it raises a one-cycle interrupt request on vector 0.

Software programs the ring through a small word-addressed register port. Word 0 holds the low half of the base address and word 1 the high half. Word 2 holds the ring size as a power of two, word 3 the interrupt index, word 4 the head pointer and word 5 the tail pointer. Every word reads back, and word 4 returns the committed head, so software only sees events whose writes are complete.

The control is a two-state machine. In `S_IDLE` the block waits for a post. An ACCEPT moves it to `S_ISSUE` when the kind is legal and the ring has room. A DROP keeps it in `S_IDLE`: the post is consumed and flagged when the kind is illegal. A STALL also keeps it in `S_IDLE`, with ready low, while the ring is full. In `S_ISSUE` the request is held until the DMA handshake. A SENT then returns the machine to `S_IDLE` and bumps the issue pointer.

Top module: `evq_writer`

## Requirements
- R1: The DMA record carries the event kind in data bits [15:0] and the origin in bits [31:16], with every other bit zero. The request tag equals the issue head pointer at the time the request is presented.
- R2: The request address is base + ((issue head AND (2^log_size − 1)) × 32), so slots wrap at the ring size.
- R3: Only kinds 0x0000 (transmit done) and 0x0001 (receive done) are legal. An illegal post is accepted (ready high) but produces no DMA request, and it sets the sticky flag `err_kind`.
- R4: A DMA request stays valid, with address, tag and data unchanged, until `dma_req_ready`. The issue head increments by one on that handshake.
- R5: When (issue head − tail) mod 2^16 ≥ 2^log_size, `post_ready` is low and no post is taken. Writes that are still in flight count towards this occupancy, and writing the tail frees room.
- R6: A completion whose tag equals the committed head increments the committed head (read back at word 4). In the cycle after the completion, `msi_valid` pulses for one cycle with `msi_vector` = 0.
- R7: A completion whose tag differs from the committed head leaves the head unchanged, raises no interrupt and sets the sticky flag `err_order`.
- R8: After reset both head pointers, the tail, the base and log_size are zero. Writing word 4 loads both the issue and the committed head.
- R9: A SENT handshake and a matching completion in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the selected word |
| post_valid | input | 1 | Client event request |
| post_ready | output | 1 | Block can take a request |
| post_kind | input | 16 | Event kind |
| post_origin | input | 16 | Event origin |
| dma_req_valid | output | 1 | DMA write request valid |
| dma_req_ready | input | 1 | DMA engine takes the request |
| dma_req_addr | output | 64 | Host byte address of the slot |
| dma_req_tag | output | 16 | Request tag (issue head) |
| dma_req_data | output | 256 | 32-byte event record |
| dma_cpl_valid | input | 1 | DMA write completion |
| dma_cpl_tag | input | 16 | Tag of the completed write |
| msi_valid | output | 1 | Interrupt request pulse |
| msi_vector | output | 5 | Interrupt vector (always 0) |
| err_kind | output | 1 | Sticky: illegal kind seen |
| err_order | output | 1 | Sticky: out-of-order completion |

## Verification
The issue side and the commit side advance separate pointers, and both can move in the same clock: a SENT handshake for one event can coincide with the completion of an earlier event. The bench leaves one write in flight and posts a second. It then raises `dma_req_ready` and a completion for the older tag on the same edge. It judges the result by the head readback, the interrupt pulse, and the tag and address of the following request and completion.

// File: rtl/evq_pkg.sv
package evq_pkg;
    localparam int ADDR_W    = 64;
    localparam int REC_BYTES = 32;
    localparam int DATA_W    = REC_BYTES * 8;
    localparam int REC_SHIFT = $clog2(REC_BYTES);

    localparam logic [15:0] KIND_TX_DONE = 16'h0000;
    localparam logic [15:0] KIND_RX_DONE = 16'h0001;

    localparam logic [2:0] W_BASE_LO = 3'd0;
    localparam logic [2:0] W_BASE_HI = 3'd1;
    localparam logic [2:0] W_LOGSZ   = 3'd2;
    localparam logic [2:0] W_IRQ     = 3'd3;
    localparam logic [2:0] W_HEAD    = 3'd4;
    localparam logic [2:0] W_TAIL    = 3'd5;

    typedef enum logic [0:0] {
        S_IDLE  = 1'b0,
        S_ISSUE = 1'b1
    } evq_state_e;
endpackage

// File: rtl/evq_regs.sv
module evq_regs
    import evq_pkg::*;
#(
    parameter int PTR_W = 16,
    parameter int LOG_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [2:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    input  logic [PTR_W-1:0]     commit_head,
    output logic [31:0]          reg_rdata,
    output logic [ADDR_W-1:0]    base,
    output logic [LOG_W-1:0]     log_size,
    output logic [PTR_W-1:0]     tail,
    output logic                 head_load,
    output logic [PTR_W-1:0]     head_value
);
    logic [31:0] base_lo_q, base_hi_q, irq_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_lo_q <= '0;
            base_hi_q <= '0;
            irq_q     <= '0;
            log_size  <= '0;
            tail      <= '0;
        end else if (reg_we) begin
            unique case (reg_addr)
                W_BASE_LO: base_lo_q <= reg_wdata;
                W_BASE_HI: base_hi_q <= reg_wdata;
                W_LOGSZ:   log_size  <= reg_wdata[LOG_W-1:0];
                W_IRQ:     irq_q     <= reg_wdata;
                W_TAIL:    tail      <= reg_wdata[PTR_W-1:0];
                default:   ;
            endcase
        end
    end

    assign base       = {base_hi_q, base_lo_q};
    assign head_load  = reg_we && (reg_addr == W_HEAD);
    assign head_value = reg_wdata[PTR_W-1:0];

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            W_BASE_LO: reg_rdata = base_lo_q;
            W_BASE_HI: reg_rdata = base_hi_q;
            W_LOGSZ:   reg_rdata = 32'(log_size);
            W_IRQ:     reg_rdata = irq_q;
            W_HEAD:    reg_rdata = 32'(commit_head);
            W_TAIL:    reg_rdata = 32'(tail);
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/evq_issue.sv
module evq_issue
    import evq_pkg::*;
#(
    parameter int PTR_W = 16,
    parameter int LOG_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 post_valid,
    input  logic [15:0]          post_kind,
    input  logic [15:0]          post_origin,
    output logic                 post_ready,
    output logic                 dma_req_valid,
    input  logic                 dma_req_ready,
    output logic [ADDR_W-1:0]    dma_req_addr,
    output logic [PTR_W-1:0]     dma_req_tag,
    output logic [DATA_W-1:0]    dma_req_data,
    input  logic [ADDR_W-1:0]    base,
    input  logic [LOG_W-1:0]     log_size,
    input  logic [PTR_W-1:0]     tail,
    input  logic                 head_load,
    input  logic [PTR_W-1:0]     head_value,
    output logic [PTR_W-1:0]     issue_head,
    output logic                 err_kind
);
    evq_state_e state_q, state_d;

    logic [PTR_W:0]   ring_size;
    logic [PTR_W-1:0] slot_mask, slot, occupancy;
    logic             ring_full, kind_ok, take_good, take_bad, sent;
    logic [15:0]      kind_q, origin_q;

    assign ring_size = {{PTR_W{1'b0}}, 1'b1} << log_size;
    assign slot_mask = PTR_W'(ring_size - 1'b1);
    assign occupancy = issue_head - tail;
    assign ring_full = {1'b0, occupancy} >= ring_size;
    assign kind_ok   = (post_kind == KIND_TX_DONE) || (post_kind == KIND_RX_DONE);
    assign slot      = issue_head & slot_mask;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state and outputs
    always_comb begin
        state_d       = state_q;
        post_ready    = 1'b0;
        dma_req_valid = 1'b0;
        take_good     = 1'b0;
        take_bad      = 1'b0;
        sent          = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                post_ready = !ring_full;
                if (post_valid && !ring_full) begin
                    if (kind_ok) begin
                        take_good = 1'b1;
                        state_d   = S_ISSUE;
                    end else begin
                        take_bad  = 1'b1;
                    end
                end
            end
            S_ISSUE: begin
                dma_req_valid = 1'b1;
                if (dma_req_ready) begin
                    sent    = 1'b1;
                    state_d = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issue_head <= '0;
            kind_q     <= '0;
            origin_q   <= '0;
            err_kind   <= 1'b0;
        end else begin
            if (head_load)  issue_head <= head_value;
            else if (sent)  issue_head <= issue_head + 1'b1;
            if (take_good) begin
                kind_q   <= post_kind;
                origin_q <= post_origin;
            end
            if (take_bad)   err_kind <= 1'b1;
        end
    end

    assign dma_req_tag  = issue_head;
    assign dma_req_addr = base + ({{(ADDR_W-PTR_W){1'b0}}, slot} << REC_SHIFT);
    assign dma_req_data = {{(DATA_W-32){1'b0}}, origin_q, kind_q};
endmodule

// File: rtl/evq_commit.sv
module evq_commit #(
    parameter int PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dma_cpl_valid,
    input  logic [PTR_W-1:0] dma_cpl_tag,
    input  logic             head_load,
    input  logic [PTR_W-1:0] head_value,
    output logic [PTR_W-1:0] commit_head,
    output logic             msi_valid,
    output logic             err_order
);
    logic in_order;
    assign in_order = dma_cpl_tag == commit_head;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_head <= '0;
            msi_valid   <= 1'b0;
            err_order   <= 1'b0;
        end else begin
            msi_valid <= dma_cpl_valid && in_order && !head_load;
            if (head_load)
                commit_head <= head_value;
            else if (dma_cpl_valid && in_order)
                commit_head <= commit_head + 1'b1;
            if (dma_cpl_valid && !in_order)
                err_order <= 1'b1;
        end
    end
endmodule

// File: rtl/evq_writer.sv
module evq_writer
    import evq_pkg::*;
#(
    parameter int PTR_W = 16,
    parameter int LOG_W = 4,
    parameter int VEC_W = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [2:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic                 post_valid,
    output logic                 post_ready,
    input  logic [15:0]          post_kind,
    input  logic [15:0]          post_origin,
    output logic                 dma_req_valid,
    input  logic                 dma_req_ready,
    output logic [ADDR_W-1:0]    dma_req_addr,
    output logic [PTR_W-1:0]     dma_req_tag,
    output logic [DATA_W-1:0]    dma_req_data,
    input  logic                 dma_cpl_valid,
    input  logic [PTR_W-1:0]     dma_cpl_tag,
    output logic                 msi_valid,
    output logic [VEC_W-1:0]     msi_vector,
    output logic                 err_kind,
    output logic                 err_order
);
    logic [ADDR_W-1:0] base;
    logic [LOG_W-1:0]  log_size;
    logic [PTR_W-1:0]  tail, head_value, commit_head, issue_head;
    logic              head_load;

    evq_regs #(.PTR_W(PTR_W), .LOG_W(LOG_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .commit_head(commit_head), .reg_rdata(reg_rdata),
        .base(base), .log_size(log_size), .tail(tail),
        .head_load(head_load), .head_value(head_value)
    );

    evq_issue #(.PTR_W(PTR_W), .LOG_W(LOG_W)) u_issue (
        .clk(clk), .rst_n(rst_n),
        .post_valid(post_valid), .post_kind(post_kind), .post_origin(post_origin),
        .post_ready(post_ready),
        .dma_req_valid(dma_req_valid), .dma_req_ready(dma_req_ready),
        .dma_req_addr(dma_req_addr), .dma_req_tag(dma_req_tag),
        .dma_req_data(dma_req_data),
        .base(base), .log_size(log_size), .tail(tail),
        .head_load(head_load), .head_value(head_value),
        .issue_head(issue_head), .err_kind(err_kind)
    );

    evq_commit #(.PTR_W(PTR_W)) u_commit (
        .clk(clk), .rst_n(rst_n),
        .dma_cpl_valid(dma_cpl_valid), .dma_cpl_tag(dma_cpl_tag),
        .head_load(head_load), .head_value(head_value),
        .commit_head(commit_head), .msi_valid(msi_valid), .err_order(err_order)
    );

    assign msi_vector = '0;
endmodule

// File: rtl/evq_checker.sv
module evq_checker
    import evq_pkg::*;
#(
    parameter int PTR_W = 16,
    parameter int LOG_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dma_req_valid,
    input logic              dma_req_ready,
    input logic [ADDR_W-1:0] dma_req_addr,
    input logic [PTR_W-1:0]  dma_req_tag,
    input logic [DATA_W-1:0] dma_req_data,
    input logic              dma_cpl_valid,
    input logic              msi_valid,
    input logic              err_kind,
    input logic              err_order,
    input logic [PTR_W-1:0]  issue_head,
    input logic [PTR_W-1:0]  tail,
    input logic [LOG_W-1:0]  log_size
);
    a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req_valid && !dma_req_ready |=> dma_req_valid && $stable(dma_req_addr)
            && $stable(dma_req_tag) && $stable(dma_req_data));

    a_r1_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req_valid |-> dma_req_data[DATA_W-1:32] == '0);

    a_r3_legal_kind: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req_valid |-> dma_req_data[15:1] == '0);

    a_r5_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req_valid |-> ({1'b0, PTR_W'(issue_head - tail)} < ({{PTR_W{1'b0}}, 1'b1} << log_size)));

    a_r6_msi_cause: assert property (@(posedge clk) disable iff (!rst_n)
        msi_valid |-> $past(dma_cpl_valid));

    a_r3_kind_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_kind |=> err_kind);

    a_r7_order_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_order |=> err_order);
endmodule

bind evq_writer evq_checker #(.PTR_W(PTR_W), .LOG_W(LOG_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .dma_req_valid(dma_req_valid), .dma_req_ready(dma_req_ready),
    .dma_req_addr(dma_req_addr), .dma_req_tag(dma_req_tag),
    .dma_req_data(dma_req_data), .dma_cpl_valid(dma_cpl_valid),
    .msi_valid(msi_valid), .err_kind(err_kind), .err_order(err_order),
    .issue_head(issue_head), .tail(tail), .log_size(log_size)
);

// File: tb/tb_evq_writer.sv
module tb_evq_writer;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_we = 1'b0;
    logic [2:0]   reg_addr = 3'd0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         post_valid = 1'b0;
    logic         post_ready;
    logic [15:0]  post_kind = '0, post_origin = '0;
    logic         dma_req_valid;
    logic         dma_req_ready = 1'b0;
    logic [63:0]  dma_req_addr;
    logic [15:0]  dma_req_tag;
    logic [255:0] dma_req_data;
    logic         dma_cpl_valid = 1'b0;
    logic [15:0]  dma_cpl_tag = '0;
    logic         msi_valid;
    logic [4:0]   msi_vector;
    logic         err_kind, err_order;

    int  n_chk = 0, n_fail = 0;
    bit  done = 1'b0;
    localparam logic [63:0] BASE = 64'h0000_0001_0000_1000;

    always #10 clk = ~clk;

    evq_writer dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .post_valid(post_valid), .post_ready(post_ready),
        .post_kind(post_kind), .post_origin(post_origin),
        .dma_req_valid(dma_req_valid), .dma_req_ready(dma_req_ready),
        .dma_req_addr(dma_req_addr), .dma_req_tag(dma_req_tag),
        .dma_req_data(dma_req_data), .dma_cpl_valid(dma_cpl_valid),
        .dma_cpl_tag(dma_cpl_tag), .msi_valid(msi_valid), .msi_vector(msi_vector),
        .err_kind(err_kind), .err_order(err_order)
    );

    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic read_head(output logic [31:0] v);
        reg_addr = 3'd4; #1; v = reg_rdata;
    endtask

    // Post one event; returns at the negedge after the accepting edge.
    task automatic post_event(input logic [15:0] k, input logic [15:0] o);
        @(negedge clk); post_valid = 1'b1; post_kind = k; post_origin = o;
        @(negedge clk); post_valid = 1'b0;
    endtask

    task automatic dma_take();
        dma_req_ready = 1'b1;
        @(negedge clk); dma_req_ready = 1'b0;
    endtask

    task automatic complete(input logic [15:0] t);
        @(negedge clk); dma_cpl_valid = 1'b1; dma_cpl_tag = t;
        @(negedge clk); dma_cpl_valid = 1'b0;
    endtask

    task automatic issue_and_check(input logic [15:0] k, input logic [15:0] o,
                                   input logic [15:0] tag, input logic [63:0] addr);
        post_event(k, o);
        chk("R4 request valid", 256'(dma_req_valid), 256'd1);
        chk("R1 tag", 256'(dma_req_tag), 256'(tag));
        chk("R2 address", 256'(dma_req_addr), 256'(addr));
        chk("R1 record", dma_req_data, {224'd0, o, k});
        @(negedge clk);
        chk("R4 held until ready", 256'(dma_req_valid), 256'd1);
        dma_take();
        chk("R4 request retired", 256'(dma_req_valid), 256'd0);
    endtask

    task automatic complete_and_check(input logic [15:0] t, input logic [15:0] head_exp);
        logic [31:0] h;
        complete(t);
        chk("R6 msi pulse", 256'(msi_valid), 256'd1);
        chk("R6 msi vector", 256'(msi_vector), 256'd0);
        read_head(h);
        chk("R6 head advanced", 256'(h), 256'(head_exp));
        @(negedge clk);
        chk("R6 msi single cycle", 256'(msi_valid), 256'd0);
    endtask

    task automatic t_reset();
        logic [31:0] h;
        read_head(h);
        chk("R8 head after reset", 256'(h), 256'd0);
        reg_addr = 3'd5; #1;
        chk("R8 tail after reset", 256'(reg_rdata), 256'd0);
        chk("R8 no request after reset", 256'(dma_req_valid), 256'd0);
        chk("R8 ready after reset", 256'(post_ready), 256'd1);
        chk("R8 flags clear", 256'({msi_valid, err_kind, err_order}), 256'd0);
    endtask

    task automatic t_basic();
        reg_write(3'd0, BASE[31:0]);
        reg_write(3'd1, BASE[63:32]);
        reg_write(3'd2, 32'd3);
        issue_and_check(16'h0000, 16'h0007, 16'd0, BASE);
        complete_and_check(16'd0, 16'd1);
    endtask

    task automatic t_wrap();
        logic [31:0] h;
        reg_write(3'd5, 32'd7);
        reg_write(3'd4, 32'd7);
        read_head(h);
        chk("R8 head write readback", 256'(h), 256'd7);
        issue_and_check(16'h0001, 16'h00A5, 16'd7, BASE + 64'h0E0);
        complete_and_check(16'd7, 16'd8);
        issue_and_check(16'h0000, 16'h1234, 16'd8, BASE);
        complete_and_check(16'd8, 16'd9);
    endtask

    task automatic t_illegal();
        chk("R3 flag clear before", 256'(err_kind), 256'd0);
        @(negedge clk);
        post_valid = 1'b1; post_kind = 16'h0005; post_origin = 16'h0003;
        #1 chk("R3 illegal post ready", 256'(post_ready), 256'd1);
        @(negedge clk); post_valid = 1'b0;
        chk("R3 no request", 256'(dma_req_valid), 256'd0);
        chk("R3 sticky flag", 256'(err_kind), 256'd1);
        @(negedge clk);
        chk("R3 still no request", 256'(dma_req_valid), 256'd0);
    endtask

    task automatic t_collision();
        logic [31:0] h;
        issue_and_check(16'h0000, 16'h0011, 16'd9, BASE + 64'h020);
        post_event(16'h0001, 16'h0022);
        chk("R9 second request tag", 256'(dma_req_tag), 256'd10);
        chk("R9 second request addr", 256'(dma_req_addr), 256'(BASE + 64'h040));
        dma_req_ready = 1'b1; dma_cpl_valid = 1'b1; dma_cpl_tag = 16'd9;
        @(negedge clk);
        dma_req_ready = 1'b0; dma_cpl_valid = 1'b0;
        chk("R9 request retired", 256'(dma_req_valid), 256'd0);
        chk("R9 msi on collision", 256'(msi_valid), 256'd1);
        read_head(h);
        chk("R9 head after collision", 256'(h), 256'd10);
        complete_and_check(16'd10, 16'd11);
        issue_and_check(16'h0000, 16'h0033, 16'd11, BASE + 64'h060);
        complete_and_check(16'd11, 16'd12);
    endtask

    task automatic t_full();
        reg_write(3'd2, 32'd1);
        reg_write(3'd5, 32'd20);
        reg_write(3'd4, 32'd20);
        issue_and_check(16'h0000, 16'h0001, 16'd20, BASE);
        issue_and_check(16'h0000, 16'h0002, 16'd21, BASE + 64'h020);
        chk("R5 ready low when full", 256'(post_ready), 256'd0);
        post_valid = 1'b1; post_kind = 16'h0000;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R5 no request when full", 256'(dma_req_valid), 256'd0);
            chk("R5 ready stays low", 256'(post_ready), 256'd0);
        end
        post_valid = 1'b0;
        complete_and_check(16'd20, 16'd21);
        chk("R5 completion does not free room", 256'(post_ready), 256'd0);
        reg_write(3'd5, 32'd21);
        chk("R5 tail write frees room", 256'(post_ready), 256'd1);
        complete_and_check(16'd21, 16'd22);
        issue_and_check(16'h0001, 16'h0004, 16'd22, BASE);
        complete_and_check(16'd22, 16'd23);
    endtask

    task automatic t_bad_tag();
        logic [31:0] h;
        chk("R7 flag clear before", 256'(err_order), 256'd0);
        complete(16'h0055);
        chk("R7 no msi", 256'(msi_valid), 256'd0);
        read_head(h);
        chk("R7 head unchanged", 256'(h), 256'd23);
        chk("R7 sticky flag", 256'(err_order), 256'd1);
        @(negedge clk);
        chk("R7 flag held", 256'(err_order), 256'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_wrap();
        t_illegal();
        t_collision();
        t_full();
        t_bad_tag();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule